// File: doc/BRIEF.md
# Three-State Multiplexed Bus Cycle Sequencer

This block is the bus side of a small 8-bit processor with a 16-bit address space. Each memory or port transfer runs as one machine cycle of three bus states, T1, T2 and T3. The upper address byte has pins of its own. The lower address byte and the data byte take turns on a single 8-bit shared bus. During T1 the lower address appears on the shared bus, and a latch-enable pulse lets external latches capture it. During T2 and T3 the shared bus carries data, and an active-low read or write strobe is asserted.

The core side offers a transfer as address, write data, a port-or-memory flag and a direction. The block accepts it with a ready signal and returns read data with a one-clock valid pulse. The block does not drive pads directly. Every tri-stateable group leaves the block as a value plus an output enable, and the pad ring builds the real high-impedance drivers. Bus hold, halt and reset all drop those enables. The latch-enable pin has no enable and is always driven.

Each bus state lasts `PH_PER_T` clocks, two by default. The latch enable is high in the first half of T1 and low in the second half. The address is therefore still stable when the latch enable falls.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is high only when the block is idle, out of reset, and neither `hold_req` nor `halt_req` is high. A transfer is accepted on a clock edge where `req_valid` and `req_ready` are both high. It then runs T1, T2 and T3, each two clocks long, and returns to idle for at least one clock before the next transfer can start.
- R2: During both clocks of T1, `ahi` equals address bits [15:8], `ad_out` equals address bits [7:0], and `ad_oe` is 1. `ahi_en` is 1 from T1 through T3 and 0 at all other times.
- R3: `ale` is 1 only in the first clock of T1 and 0 at all other times, including hold, halt and reset.
- R4: Status is held constant from T1 through T3. `iom` is 1 for a port transfer and 0 for a memory transfer. `{s1,s0}` is 2'b10 for a read and 2'b01 for a write. In idle `{s1,s0}` is 2'b11 and `iom` is 0.
- R5: `rd_n` is 0 during the four clocks of T2 and T3 of a read. `wr_n` is 0 during the same clocks of a write. Otherwise both are 1, and they are never 0 together.
- R6: In T2 and T3 of a write, `ad_oe` is 1 and `ad_out` carries the write data. In T2 and T3 of a read, `ad_oe` is 0.
- R7: A read samples `ad_in` on the clock edge that ends T3. `rsp_rdata` then shows that byte, and `rsp_valid` is 1 for the single following clock. A write never raises `rsp_valid`.
- R8: A hold request is granted only from idle; one that arrives during a transfer lets the transfer finish unchanged. `hlda` rises one clock after idle is reached. While `hlda` is 1, `ahi_en`, `ad_oe`, `ctl_en` and `ale` are 0 and no transfer is accepted. When `hold_req` falls, the block returns to idle on the next clock.
- R9: With `halt_req` high in idle and no hold request, the block enters a halt state on the next clock. In halt, `{s1,s0}` is 2'b00, `ahi_en` and `ad_oe` are 0, and `rd_n` and `wr_n` are 1. When `hold_req` and `halt_req` are both high in idle, hold is granted first.
- R10: While `rst_n` is 0, `ahi_en`, `ad_oe`, `ctl_en`, `ale`, `hlda`, `rsp_valid` and `req_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state is PH_PER_T clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Transfer can be accepted this clock |
| req_io | input | 1 | 1 = port transfer, 0 = memory transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 8 | Last byte read |
| hold_req | input | 1 | External bus hold request |
| hlda | output | 1 | Hold granted |
| halt_req | input | 1 | Core requests the halt state |
| ale | output | 1 | Address latch enable, always driven |
| ahi | output | 8 | Upper address byte value |
| ahi_en | output | 1 | Output enable for ahi |
| ad_out | output | 8 | Shared bus outgoing value |
| ad_oe | output | 1 | Output enable for the shared bus |
| ad_in | input | 8 | Shared bus incoming value |
| iom | output | 1 | Port/memory status |
| s1 | output | 1 | Cycle-type status, upper bit |
| s0 | output | 1 | Cycle-type status, lower bit |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ctl_en | output | 1 | Output enable for rd_n, wr_n and iom |

## Verification
A wrong state or phase count shows up within a clock as a mistimed `ale`: a pulse that lasts two clocks, one outside T1, or an `ale` that falls after the shared bus has already switched to data. A miscounted T-state moves a strobe edge or shortens T3. The read sample then lands on the wrong edge, so `rsp_rdata` differs from what the bench's memory model put on `ad_in`, and `rsp_valid` appears one clock early or late. A hold or halt taken at the wrong time shows in the first clock as `hlda` rising in the middle of a transfer, or as an enable still high in the state that should release the bus.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_HOLD = 3'd4,
    ST_HALT = 3'd5
  } bus_st_e;

  // true while a machine cycle owns the bus
  function automatic logic in_cycle(input bus_st_e st);
    return (st == ST_T1) || (st == ST_T2) || (st == ST_T3);
  endfunction

  // cycle-type code: read 10, write 01, halt 00, idle/hold 11
  function automatic logic [1:0] status_code(input bus_st_e st, input logic wr);
    if (in_cycle(st)) return wr ? 2'b01 : 2'b10;
    if (st == ST_HALT) return 2'b00;
    return 2'b11;
  endfunction

  // strobe window covers the data states
  function automatic logic data_phase(input bus_st_e st);
    return (st == ST_T2) || (st == ST_T3);
  endfunction

endpackage

// File: rtl/mbs_tstate.sv
module mbs_tstate
  import mux_bus_pkg::*;
#(
  parameter int PH_PER_T = 2,
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            hold_req,
  input  logic            halt_req,
  output bus_st_e         st,
  output logic [PH_W-1:0] ph,
  output logic            req_ready,
  output logic            accept,
  output logic            cycle_end,
  output logic            early_half
);

  bus_st_e st_nx;
  logic    last_ph;

  assign last_ph    = (ph == PH_W'(PH_PER_T - 1));
  assign req_ready  = rst_n && (st == ST_IDLE) && !hold_req && !halt_req;
  assign accept     = req_ready && req_valid;
  assign cycle_end  = (st == ST_T3) && last_ph;
  assign early_half = (int'(ph) < (PH_PER_T / 2));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (hold_req)       st_nx = ST_HOLD;
        else if (halt_req)  st_nx = ST_HALT;
        else if (req_valid) st_nx = ST_T1;
      end
      ST_T1:   if (last_ph) st_nx = ST_T2;
      ST_T2:   if (last_ph) st_nx = ST_T3;
      ST_T3:   if (last_ph) st_nx = ST_IDLE;
      ST_HOLD: if (!hold_req) st_nx = ST_IDLE;
      ST_HALT: begin
        if (hold_req)       st_nx = ST_HOLD;
        else if (!halt_req) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ph <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st || !in_cycle(st)) ph <= '0;
      else                              ph <= ph + PH_W'(1);
    end
  end

endmodule

// File: rtl/mbs_xfer.sv
module mbs_xfer #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cycle_end,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic          cur_io,
  output logic          cur_wr,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_io    <= 1'b0;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_io    <= req_io;
      cur_wr    <= req_write;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cycle_end && !cur_wr;
      if (cycle_end && !cur_wr) rsp_rdata <= ad_in;
    end
  end

endmodule

// File: rtl/mbs_pads.sv
module mbs_pads
  import mux_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          rst_n,
  input  bus_st_e       st,
  input  logic          early_half,
  input  logic          cur_io,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  output logic          ale,
  output logic [HW-1:0] ahi,
  output logic          ahi_en,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          iom,
  output logic          s1,
  output logic          s0,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_en,
  output logic          hlda
);

  logic busy;
  logic strobe;

  assign busy     = in_cycle(st);
  assign strobe   = data_phase(st);
  assign ale      = (st == ST_T1) && early_half;
  assign ahi      = cur_addr[AW-1:DW];
  assign ahi_en   = busy;
  assign ad_out   = (st == ST_T1) ? cur_addr[DW-1:0] : cur_wdata;
  assign ad_oe    = (st == ST_T1) || (strobe && cur_wr);
  assign iom      = busy && cur_io;
  assign {s1, s0} = status_code(st, cur_wr);
  assign rd_n     = !(strobe && !cur_wr);
  assign wr_n     = !(strobe && cur_wr);
  assign hlda     = (st == ST_HOLD);
  assign ctl_en   = rst_n && (st != ST_HOLD);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PH_PER_T = 2,
  localparam int HW   = AW - DW,
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          hold_req,
  output logic          hlda,
  input  logic          halt_req,
  output logic          ale,
  output logic [HW-1:0] ahi,
  output logic          ahi_en,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          iom,
  output logic          s1,
  output logic          s0,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_en
);

  bus_st_e          st;
  logic [PH_W-1:0]  ph;
  logic             accept;
  logic             cycle_end;
  logic             early_half;
  logic             cur_io;
  logic             cur_wr;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    cur_wdata;

  mbs_tstate #(.PH_PER_T(PH_PER_T)) u_tstate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hold_req   (hold_req),
    .halt_req   (halt_req),
    .st         (st),
    .ph         (ph),
    .req_ready  (req_ready),
    .accept     (accept),
    .cycle_end  (cycle_end),
    .early_half (early_half)
  );

  mbs_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cycle_end (cycle_end),
    .req_io    (req_io),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .cur_io    (cur_io),
    .cur_wr    (cur_wr),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  mbs_pads #(.AW(AW), .DW(DW)) u_pads (
    .rst_n      (rst_n),
    .st         (st),
    .early_half (early_half),
    .cur_io     (cur_io),
    .cur_wr     (cur_wr),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .ale        (ale),
    .ahi        (ahi),
    .ahi_en     (ahi_en),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .iom        (iom),
    .s1         (s1),
    .s0         (s0),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ctl_en     (ctl_en),
    .hlda       (hlda)
  );

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int HW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic [HW-1:0] ahi,
  input logic          ahi_en,
  input logic [DW-1:0] ad_out,
  input logic          ad_oe,
  input logic          iom,
  input logic          s1,
  input logic          s0,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ctl_en,
  input logic          hlda,
  input logic          rsp_valid,
  input logic          cycle_end
);

  a_r3_ale_inside_t1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && ahi_en && rd_n && wr_n));

  a_r2_addr_held_at_ale_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out) && $stable(ahi)));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r6_read_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r8_hold_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ahi_en && !ad_oe && !ctl_en && !ale));

  a_r8_hold_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !$past(ahi_en));

  a_r4_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ahi_en && $past(ahi_en)) |-> $stable({iom, s1, s0}));

  a_r7_rsp_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cycle_end));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!ahi_en && !ad_oe && !ctl_en && !ale && !hlda && !rsp_valid);
    end
  end

endmodule

bind mux_bus_seq mux_bus_seq_chk #(.HW(HW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .ahi       (ahi),
  .ahi_en    (ahi_en),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .iom       (iom),
  .s1        (s1),
  .s0        (s0),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ctl_en    (ctl_en),
  .hlda      (hlda),
  .rsp_valid (rsp_valid),
  .cycle_end (cycle_end)
);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;

  typedef struct {
    logic        io;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic hold_req = 1'b0, halt_req = 1'b0;
  logic req_ready, rsp_valid, hlda, ale, ahi_en, ad_oe, iom, s1, s0, rd_n, wr_n, ctl_en;
  logic [7:0] rsp_rdata, ahi, ad_out, ad_in, lat_lo;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  item_t q[$];

  always #5 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hold_req(hold_req), .hlda(hlda),
    .halt_req(halt_req), .ale(ale), .ahi(ahi), .ahi_en(ahi_en), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .iom(iom), .s1(s1), .s0(s0), .rd_n(rd_n),
    .wr_n(wr_n), .ctl_en(ctl_en)
  );

  // memory model: external latch catches the low byte while ale is high
  function automatic logic [7:0] memfn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(negedge clk) if (ale) lat_lo <= ad_out;
  assign ad_in = memfn({ahi, lat_lo});

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: waits for ready at a falling edge, pushes the expected transfer
  task automatic issue(input logic io, input logic wr, input logic [15:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    it.io = io; it.wr = wr; it.addr = a; it.wdata = d;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: follows each machine cycle from the ale pulse
  initial begin
    item_t cur;
    forever begin
      @(negedge clk);
      if (rst_n && ale) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected cycle", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(ahi == cur.addr[15:8], "R2 high address", ahi, cur.addr[15:8]);
          chk(ad_oe && ad_out == cur.addr[7:0], "R2 low address T1a", ad_out, cur.addr[7:0]);
          chk({iom, s1, s0} == {cur.io, cur.wr ? 2'b01 : 2'b10}, "R4 status",
              {iom, s1, s0}, {cur.io, cur.wr ? 2'b01 : 2'b10});
          for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) begin
              chk(!ale, "R3 ale one clock", ale, 0);
              chk(ad_oe && ad_out == cur.addr[7:0], "R2 low address T1b", ad_out, cur.addr[7:0]);
              chk(rd_n && wr_n, "R5 no strobe in T1", {rd_n, wr_n}, 3);
            end else if (k <= 5) begin
              chk(rd_n == cur.wr && wr_n == !cur.wr, "R5 strobe window", {rd_n, wr_n},
                  {cur.wr, !cur.wr});
              chk(ahi_en && {iom, s1, s0} == {cur.io, cur.wr ? 2'b01 : 2'b10},
                  "R4 status held", {ahi_en, iom, s1, s0}, {1'b1, cur.io, cur.wr ? 2'b01 : 2'b10});
              if (cur.wr) chk(ad_oe && ad_out == cur.wdata, "R6 write data", ad_out, cur.wdata);
              else        chk(!ad_oe, "R6 read releases bus", ad_oe, 0);
            end else begin
              chk(rd_n && wr_n && !ahi_en, "R2 R5 idle after T3", {rd_n, wr_n, ahi_en}, 6);
              chk({iom, s1, s0} == 3'b011, "R4 idle status", {iom, s1, s0}, 3);
              chk(rsp_valid == !cur.wr, "R7 response pulse", rsp_valid, !cur.wr);
              if (!cur.wr)
                chk(rsp_rdata == memfn(cur.addr), "R7 read data", rsp_rdata, memfn(cur.addr));
            end
          end
        end
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!ahi_en && !ad_oe && !ctl_en && !ale && !hlda && !rsp_valid && !req_ready,
        "R10 reset quiet", {ahi_en, ad_oe, ctl_en, ale, hlda, rsp_valid, req_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ctl_en && rd_n && wr_n, "R1 ready after reset", {req_ready, ctl_en}, 3);

    issue(1'b0, 1'b0, 16'hA55A, 8'h00);
    issue(1'b0, 1'b1, 16'h1234, 8'hC3);
    issue(1'b1, 1'b0, 16'h7F7F, 8'h00);
    issue(1'b1, 1'b1, 16'h0080, 8'h5E);
    issue(1'b0, 1'b0, 16'hFFFF, 8'h00);
    issue(1'b0, 1'b1, 16'h0000, 8'hFF);
    drain();

    // R8: hold raised mid-cycle waits for the boundary
    issue(1'b0, 1'b0, 16'h4321, 8'h00);
    @(negedge clk);
    @(negedge clk);
    hold_req = 1'b1;
    for (int i = 3; i <= 7; i++) begin
      @(negedge clk);
      chk(hlda == (i == 7), "R8 hold grant timing", hlda, i == 7);
    end
    chk(!ahi_en && !ad_oe && !ctl_en && !ale && !req_ready, "R8 bus released in hold",
        {ahi_en, ad_oe, ctl_en, ale, req_ready}, 0);
    fork
      issue(1'b1, 1'b1, 16'h2468, 8'h9A);
      begin
        repeat (4) begin
          @(negedge clk);
          chk(hlda && !ale && !ahi_en, "R8 no transfer in hold", {hlda, ale, ahi_en}, 4);
        end
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hlda, "R8 hold release", hlda, 0);
      end
    join
    drain();

    // R9: halt state
    halt_req = 1'b1;
    @(negedge clk);
    chk({s1, s0} == 2'b00 && !ahi_en && !ad_oe && rd_n && wr_n && !req_ready,
        "R9 halt outputs", {s1, s0, ahi_en, ad_oe}, 0);
    halt_req = 1'b0;
    @(negedge clk);
    chk({s1, s0} == 2'b11, "R9 halt exit to idle", {s1, s0}, 3);
    // R9: hold wins over halt
    hold_req = 1'b1;
    halt_req = 1'b1;
    @(negedge clk);
    chk(hlda && {s1, s0} == 2'b11, "R9 hold priority", {hlda, s1, s0}, 7);
    hold_req = 1'b0;
    halt_req = 1'b0;
    repeat (2) @(negedge clk);
    issue(1'b0, 1'b0, 16'h0F0F, 8'h00);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule